// File: doc/BRIEF.md
# Gamma-Corrected Three-Channel PWM Generator

This block turns three 8-bit brightness codes into three on/off enables for LED current sinks. A 24-bit word is captured into a holding latch by a load strobe. A shared period counter advances once per reference-clock tick. Each channel's code passes through a fixed gamma curve, which gives the point in the period where that channel switches off.

Every nonzero channel switches on when the counter reaches one, so all pulses in a period start together. Each channel then stays on until its gamma off-point. Because the curve is nonlinear, low codes give very fine steps and high codes give coarse ones.

A load always restarts the period and blanks the outputs, so new colours never start part-way through a period. The counter runs on its own and wraps at a fixed full-scale length, which makes the pattern repeat without further loads.

Top module: `gpwm_rgb_driver`

## Requirements
- R1: The loaded word maps to channels as follows: channel 0 takes bits 23:16, channel 1 takes bits 15:8 and channel 2 takes bits 7:0. The `chan_on` bit i drives channel i.
- R2: A channel whose code is 0 never asserts its enable.
- R3: Every channel with a nonzero code asserts its enable in the cycle after the tick that moves the counter from 0 to 1.
- R4: When `load_stb` is high at a clock edge, the word is captured and the counter goes to 0. All enables are low from the next cycle until the next tick. A load wins over a tick in the same cycle.
- R5: After reset the latch holds zero, so all enables stay low under any number of ticks until a nonzero word is loaded.
- R6: The off-point f(c) of a code c is set by three ranges:
  - 2c for codes 1 to 7;
  - 4c-14 for codes 8 to 31;
  - 8c-138 for codes 32 to 255.

  For example, 1→2, 10→26, 32→118, 128→886 and 255→1902. The on-time per period is therefore f(c)-1 ticks.
- R7: A channel is on exactly while the counter value n satisfies 1 ≤ n ≤ f(code)-1.
- R8: The 11-bit counter advances by one per tick. It wraps from PERIOD-1 (default 2047) to 0, and the next tick starts a new lit pulse at count 1.
- R9: In a cycle with neither a tick nor a load, the counter and all enables hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gs_tick | input | 1 | Grayscale clock enable; one counter step per high cycle |
| load_stb | input | 1 | Captures `load_data` and restarts the period |
| load_data | input | 24 | Three packed 8-bit codes (channel 0 in the top byte) |
| chan_on | output | 3 | Per-channel on/off enable |

## Verification
If the counter holds a wrong value, every lit channel's edges move together. That shows at the ports in the very next cycle, as a late turn-on after a load or as a turn-off at the wrong tick. A wrong off-point from the gamma mapping changes only the pulse width of one channel, so the bench counts lit cycles over a full period for codes at each range boundary. A bad latch slice shows as a width appearing on the wrong enable bit as soon as the first tick follows the load.

// File: rtl/gpwm_pkg.sv
package gpwm_pkg;
  // Range boundaries and offsets of the piecewise-linear gamma curve
  localparam int unsigned KNEE_LO  = 8;    // first code of the x4 range
  localparam int unsigned KNEE_HI  = 32;   // first code of the x8 range
  localparam int unsigned OFS_MID  = 14;   // f = 4c - OFS_MID
  localparam int unsigned OFS_TOP  = 138;  // f = 8c - OFS_TOP
  localparam int unsigned MIN_SPAN = 1903; // shortest legal period
endpackage

// File: rtl/gpwm_gamma_rom.sv
module gpwm_gamma_rom
  import gpwm_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned OFF_W  = 11
) (
  input  logic [CODE_W-1:0] code,
  output logic [OFF_W-1:0]  off_pt
);
  localparam logic [CODE_W-1:0] K_LO  = CODE_W'(KNEE_LO);
  localparam logic [CODE_W-1:0] K_HI  = CODE_W'(KNEE_HI);
  localparam logic [OFF_W-1:0]  O_MID = OFF_W'(OFS_MID);
  localparam logic [OFF_W-1:0]  O_TOP = OFF_W'(OFS_TOP);

  logic [OFF_W-1:0] c_ext;
  logic [1:0]       seg;

  always_comb begin
    c_ext = OFF_W'(code);
    if (code == '0)      seg = 2'd0;
    else if (code < K_LO) seg = 2'd1;
    else if (code < K_HI) seg = 2'd2;
    else                  seg = 2'd3;
  end

  always_comb begin
    unique case (seg)
      2'd0:    off_pt = '0;
      2'd1:    off_pt = c_ext << 1;
      2'd2:    off_pt = (c_ext << 2) - O_MID;
      default: off_pt = (c_ext << 3) - O_TOP;
    endcase
  end
endmodule

// File: rtl/gpwm_period_ctr.sv
module gpwm_period_ctr #(
  parameter int unsigned CNT_W  = 11,
  parameter int unsigned PERIOD = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)            cnt_d = '0;
    else if (tick) begin
      if (cnt_q == LAST)  cnt_d = '0;
      else                cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/gpwm_chan_cmp.sv
module gpwm_chan_cmp #(
  parameter int unsigned CNT_W = 11
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] off_pt,
  output logic             on
);
  // Lit from count 1 up to one below the off-point; off-point 0 never lights
  always_comb on = (cnt != '0) && (cnt < off_pt);
endmodule

// File: rtl/gpwm_rgb_driver.sv
module gpwm_rgb_driver #(
  parameter int unsigned CH_N   = 3,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned CNT_W  = 11,
  parameter int unsigned PERIOD = 2048
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     gs_tick,
  input  logic                     load_stb,
  input  logic [CH_N*CODE_W-1:0]   load_data,
  output logic [CH_N-1:0]          chan_on
);
  localparam int unsigned LAT_W = CH_N * CODE_W;

  // Reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // Holding latch for the packed codes
  logic [LAT_W-1:0] lat_q, lat_d;

  always_comb begin
    lat_d = lat_q;
    if (load_stb) lat_d = load_data;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) lat_q <= '0;
    else            lat_q <= lat_d;
  end

  // Shared period counter, restarted by every load
  logic [CNT_W-1:0] cnt_q;

  gpwm_period_ctr #(.CNT_W(CNT_W), .PERIOD(PERIOD)) u_ctr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (gs_tick),
    .clear (load_stb),
    .cnt   (cnt_q)
  );

  // One gamma lookup and comparator per channel; channel 0 in the top byte
  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    logic [CODE_W-1:0] code;
    logic [CNT_W-1:0]  off_pt;

    assign code = lat_q[LAT_W-1-g*CODE_W -: CODE_W];

    gpwm_gamma_rom #(.CODE_W(CODE_W), .OFF_W(CNT_W)) u_rom (
      .code   (code),
      .off_pt (off_pt)
    );

    gpwm_chan_cmp #(.CNT_W(CNT_W)) u_cmp (
      .cnt    (cnt_q),
      .off_pt (off_pt),
      .on     (chan_on[g])
    );
  end
endmodule

// File: rtl/gpwm_rgb_checker.sv
module gpwm_rgb_checker #(
  parameter int unsigned CH_N   = 3,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned CNT_W  = 11,
  parameter int unsigned PERIOD = 2048
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   gs_tick,
  input logic                   load_stb,
  input logic [CNT_W-1:0]       cnt,
  input logic [CH_N*CODE_W-1:0] lat,
  input logic [CH_N-1:0]        chan_on
);
  localparam int unsigned      LAT_W = CH_N * CODE_W;
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(PERIOD - 1);

  // R4: a load blanks every output and restarts the count
  p_load_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> (chan_on == '0));
  p_load_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> (cnt == '0));

  // R8: one step per tick, wrap at the end of the period
  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gs_tick && !load_stb && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));
  p_count_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gs_tick && !load_stb && cnt == LAST) |=> (cnt == '0));

  // R9: nothing moves without a tick or a load
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!gs_tick && !load_stb) |=> ($stable(cnt) && $stable(chan_on)));

  // R7: count 0 is always dark
  p_dark_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (chan_on == '0));

  for (genvar g = 0; g < CH_N; g++) begin : g_chk
    // R2: a zero code never lights
    p_zero_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lat[LAT_W-1-g*CODE_W -: CODE_W] == '0) |-> !chan_on[g]);
    // R3: a nonzero code is lit at count 1
    p_lit_at_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt == CNT_W'(1)) && (lat[LAT_W-1-g*CODE_W -: CODE_W] != '0)) |-> chan_on[g]);
  end
endmodule

bind gpwm_rgb_driver gpwm_rgb_checker #(
  .CH_N(CH_N), .CODE_W(CODE_W), .CNT_W(CNT_W), .PERIOD(PERIOD)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .gs_tick  (gs_tick),
  .load_stb (load_stb),
  .cnt      (cnt_q),
  .lat      (lat_q),
  .chan_on  (chan_on)
);

// File: tb/tb_gpwm_rgb_driver.sv
`timescale 1ns/1ps
module tb_gpwm_rgb_driver;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        gs_tick;
  logic        load_stb;
  logic [23:0] load_data;
  logic [2:0]  chan_on;

  always #5 clk = ~clk;

  gpwm_rgb_driver dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .gs_tick   (gs_tick),
    .load_stb  (load_stb),
    .load_data (load_data),
    .chan_on   (chan_on)
  );

  int          n_run  = 0;
  int          n_fail = 0;
  bit          done   = 0;
  logic [2:0]  q_exp[$];
  string       q_req[$];
  int          on_acc[3];
  int          m_cnt  = 0;
  logic [23:0] m_lat  = '0;

  // Off-point from the R6 formula
  function automatic int gamma_off(int c);
    if (c == 0)      return 0;
    else if (c < 8)  return 2 * c;
    else if (c < 32) return 4 * c - 14;
    else             return 8 * c - 138;
  endfunction

  function automatic logic [2:0] model_out();
    logic [2:0] r;
    for (int ch = 0; ch < 3; ch++) begin
      int code;
      code  = int'(m_lat[23-8*ch -: 8]);
      r[ch] = (code != 0) && (m_cnt >= 1) && (m_cnt < gamma_off(code));
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, expected output queued for the monitor
  task automatic step(bit tk, bit ld, logic [23:0] d, string req);
    @(negedge clk);
    gs_tick = tk; load_stb = ld; load_data = d;
    if (ld) begin m_cnt = 0; m_lat = d; end
    else if (tk) m_cnt = (m_cnt == 2047) ? 0 : m_cnt + 1;
    @(posedge clk);
    #1;
    gs_tick = 1'b0; load_stb = 1'b0;
    q_exp.push_back(model_out());
    q_req.push_back(req);
  endtask

  // Monitor: compares against the scoreboard and accumulates lit cycles
  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      logic [2:0] e;
      string      r;
      e = q_exp.pop_front();
      r = q_req.pop_front();
      check(chan_on == e, r, int'(chan_on), int'(e));
    end
    for (int ch = 0; ch < 3; ch++) on_acc[ch] += int'(chan_on[ch]);
  end

  // Lit-cycle count over one full period after a load (R1 mapping, R6 widths)
  task automatic measure(logic [23:0] d, string req, int e0, int e1, int e2);
    step(1'b0, 1'b1, d, "R4 load");
    for (int ch = 0; ch < 3; ch++) on_acc[ch] = 0;
    for (int i = 0; i < 2048; i++) step(1'b1, 1'b0, '0, "R7 window");
    @(negedge clk);
    #1;
    check(on_acc[0] == e0, {req, " ch0"}, on_acc[0], e0);
    check(on_acc[1] == e1, {req, " ch1"}, on_acc[1], e1);
    check(on_acc[2] == e2, {req, " ch2"}, on_acc[2], e2);
  endtask

  initial begin
    #(1_900_000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; gs_tick = 1'b0; load_stb = 1'b0; load_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(chan_on == 3'b000, "R5 reset", int'(chan_on), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5: ticks alone light nothing
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, '0, "R5 idle");

    // R1 R6: range boundaries across all three channels
    measure({8'd1,  8'd32, 8'd255}, "R1 R6 set A", 1, 117, 1901);
    measure({8'd7,  8'd8,  8'd10},  "R6 set B", 13, 17, 25);
    measure({8'd31, 8'd64, 8'd128}, "R6 set C", 109, 373, 885);
    // R2: zero codes stay dark next to a lit channel
    measure({8'd0,  8'd2,  8'd0},   "R2 R1 zero", 0, 3, 0);

    // R3: first tick after load lights every nonzero channel
    step(1'b0, 1'b1, {8'd5, 8'd0, 8'd200}, "R4 load");
    step(1'b1, 1'b0, '0, "R3 first tick");
    @(negedge clk); #1;
    check(chan_on == 3'b101, "R3 direct", int'(chan_on), 5);

    // R9: no tick, no change
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, '0, "R9 hold");
    @(negedge clk); #1;
    check(chan_on == 3'b101, "R9 direct", int'(chan_on), 5);

    // R7: sparse ticks
    for (int i = 0; i < 40; i++) step(i % 3 != 0, 1'b0, '0, "R7 sparse");

    // R4: reload mid-period together with a tick
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, '0, "R7 run");
    step(1'b1, 1'b1, {8'd3, 8'd3, 8'd3}, "R4 load beats tick");
    @(negedge clk); #1;
    check(chan_on == 3'b000, "R4 direct", int'(chan_on), 0);
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, '0, "R4 restart");

    // R8: wrap to a second period
    step(1'b0, 1'b1, {8'd2, 8'd0, 8'd1}, "R4 load");
    for (int i = 0; i < 2049; i++) step(1'b1, 1'b0, '0, "R8 wrap");
    @(negedge clk); #1;
    check(chan_on == 3'b101, "R8 relit at count 1", int'(chan_on), 5);
    step(1'b1, 1'b0, '0, "R8 second tick");
    @(negedge clk); #1;
    check(chan_on == 3'b001, "R8 code1 off at 2", int'(chan_on), 1);

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule